// File: doc/BRIEF.md
# Streaming RGB to HSL Pixel Converter

This block turns a stream of packed RGB pixels into packed HSL pixels, one pixel per clock. Each pixel carries its own hue rotation angle in degrees. The angle is added to the computed hue modulo a full turn, so any chosen colour can be placed at hue zero. Both edges of the block use a valid/ready handshake, so it can sit between other streaming stages of an image pipeline.

The datapath is fully pipelined. A max/min front stage picks the dominant channel and forms two numerator/denominator pairs. Two pipelined restoring dividers then run side by side, one for saturation and one for the hue fraction. A hue stage follows that applies the sector base, the rotation and the wrap. Last comes an output register that scales the hue to a byte. With a 16-bit dividend the pipeline has 19 register stages.

The output register alone decides backpressure. When it holds a result that downstream has not taken, every stage freezes together and the input stops accepting.

Top module: `rgbhsl_conv`

## Requirements
- R1: Input channels are packed blue in bits [7:0], green in [15:8] and red in [23:16]. Bits [31:24] of the input have no effect. The output packs lightness in [7:0], saturation in [15:8] and hue in [23:16], and bits [31:24] are always zero.
- R2: Lightness equals floor((max+min)/2) over the three input channels.
- R3: When max differs from min, saturation equals floor((max-min)*255/D). D is max+min when lightness is below 128, and 510-max-min otherwise.
- R4: The unrotated hue in degrees comes from the dominant channel, with red winning ties over green and green over blue. For red, the base is 0 and n = G-B. For green, the base is 120 and n = B-R. For blue, the base is 240 and n = R-G. The hue is base + floor(60*|n|/(max-min)) when n is 0 or more, and base minus that amount when n is negative. A negative result has 360 added. Pure red with zero rotation therefore gives hue byte 0.
- R5: When max equals min, saturation is 0 and the unrotated hue is 0, but the rotation is still applied.
- R6: The rotation input (0 to 360) is added to the unrotated hue modulo 360, so a rotation of 360 acts like 0.
- R7: The output hue byte is floor(h*256/360), where h is the rotated hue in degrees.
- R8: With output ready held high, a new pixel is accepted on every clock. Output valid for a pixel rises at the 18th rising edge after the edge that accepted it.
- R9: While output valid is high and output ready is low, the output word stays unchanged and input ready is low. Every accepted pixel leaves exactly once and in order.
- R10: A synchronous reset clears every valid bit. After reset, output valid is low and input ready is high until new pixels arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input pixel present |
| in_ready | output | 1 | Block can take an input pixel this cycle |
| in_pixel | input | 32 | Packed RGB pixel |
| hue_offset | input | 9 | Hue rotation in degrees (0 to 360), sampled with the pixel |
| out_valid | output | 1 | Output pixel present |
| out_ready | input | 1 | Downstream can take the output pixel |
| out_pixel | output | 32 | Packed HSL pixel |

## Verification
The bench aims at the colour corners. Primaries, secondaries, greys, black and white expose a wrong sector priority, a negative hue that is not wrapped, or a division by zero that is not masked on achromatic pixels. Garbage in the top input byte and rotations of 0, 359 and 360 catch a wrongly decoded field and an off-by-one in the modulo. Random stalls catch a stage that keeps moving while the output is held, which would drop or repeat pixels. An exact latency check and a reset taken with a full pipeline catch a stage count that is off by one and valid bits that survive reset.

// File: rtl/rgbhsl_pkg.sv
package rgbhsl_pkg;

    localparam int CH_W      = 8;    // bits per colour channel
    localparam int PIX_W     = 32;   // packed pixel width
    localparam int DEG_W     = 9;    // degrees 0..511
    localparam int FULL_TURN = 360;
    localparam int DIV_NUM_W = 2 * CH_W;   // holds 255*255
    localparam int DIV_DEN_W = CH_W + 1;   // holds 510

    typedef enum logic [1:0] {
        SEC_RED   = 2'd0,
        SEC_GREEN = 2'd1,
        SEC_BLUE  = 2'd2
    } sector_e;

    // travels beside the saturation divider
    typedef struct packed {
        logic             achrom;
        logic [CH_W-1:0]  light;
        logic [DEG_W-1:0] offset;
    } side_t;

    // travels beside the hue divider
    typedef struct packed {
        sector_e sector;
        logic    neg;
    } hue_tag_t;

    function automatic logic [DEG_W-1:0] sector_base(sector_e s);
        case (s)
            SEC_GREEN: return DEG_W'(120);
            SEC_BLUE:  return DEG_W'(240);
            default:   return '0;
        endcase
    endfunction

    function automatic logic [CH_W-1:0] deg_to_byte(logic [DEG_W-1:0] h);
        logic [DEG_W+CH_W-1:0] w;
        w = {h, {CH_W{1'b0}}};
        return CH_W'(w / (DEG_W+CH_W)'(FULL_TURN));
    endfunction

endpackage

// File: rtl/rgbhsl_front.sv
module rgbhsl_front
    import rgbhsl_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 adv,
    input  logic                 in_vld,
    input  logic [3*CH_W-1:0]    rgb,
    input  logic [DEG_W-1:0]     offset,
    output logic                 vld_q,
    output logic [DIV_NUM_W-1:0] sat_num_q,
    output logic [DIV_DEN_W-1:0] sat_den_q,
    output logic [DIV_NUM_W-1:0] hue_num_q,
    output logic [DIV_DEN_W-1:0] hue_den_q,
    output side_t                side_q,
    output hue_tag_t             htag_q
);

    logic [CH_W-1:0]  r, g, b, mx, mn, hi, lo, mag, delta;
    logic [CH_W:0]    sum;
    sector_e          sec;
    logic             neg;

    always_comb begin
        r = rgb[3*CH_W-1:2*CH_W];
        g = rgb[2*CH_W-1:CH_W];
        b = rgb[CH_W-1:0];
        if (r >= g && r >= b) begin
            sec = SEC_RED;   mx = r; mn = (g < b) ? g : b; hi = g; lo = b;
        end else if (g >= b) begin
            sec = SEC_GREEN; mx = g; mn = (r < b) ? r : b; hi = b; lo = r;
        end else begin
            sec = SEC_BLUE;  mx = b; mn = (r < g) ? r : g; hi = r; lo = g;
        end
        neg   = hi < lo;
        mag   = neg ? lo - hi : hi - lo;
        delta = mx - mn;
        sum   = {1'b0, mx} + {1'b0, mn};
    end

    always_ff @(posedge clk) begin
        if (rst)      vld_q <= 1'b0;
        else if (adv) vld_q <= in_vld;
        if (adv) begin
            sat_num_q     <= DIV_NUM_W'(delta) * DIV_NUM_W'(255);
            sat_den_q     <= sum[CH_W] ? DIV_DEN_W'(510) - sum : sum;
            hue_num_q     <= DIV_NUM_W'(mag) * DIV_NUM_W'(60);
            hue_den_q     <= {1'b0, delta};
            side_q.achrom <= (delta == '0);
            side_q.light  <= sum[CH_W:1];
            side_q.offset <= offset;
            htag_q.sector <= sec;
            htag_q.neg    <= neg;
        end
    end

endmodule

// File: rtl/rgbhsl_div.sv
module rgbhsl_div #(
    parameter int NUM_W = 16,
    parameter int DEN_W = 9,
    parameter int TAG_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adv,
    input  logic             in_vld,
    input  logic [NUM_W-1:0] in_num,
    input  logic [DEN_W-1:0] in_den,
    input  logic [TAG_W-1:0] in_tag,
    output logic             out_vld,
    output logic [NUM_W-1:0] out_quo,
    output logic [TAG_W-1:0] out_tag
);

    typedef struct packed {
        logic             vld;
        logic [DEN_W-1:0] rem;
        logic [NUM_W-1:0] quo;
        logic [NUM_W-1:0] num;
        logic [DEN_W-1:0] den;
        logic [TAG_W-1:0] tag;
    } stage_t;

    stage_t st_in;
    stage_t st_q [1:NUM_W];

    assign st_in = '{vld: in_vld, rem: '0, quo: '0, num: in_num, den: in_den, tag: in_tag};

    // one quotient bit per stage, most significant first
    for (genvar k = 0; k < NUM_W; k++) begin : g_stage
        stage_t         cur;
        logic [DEN_W:0] trial;
        logic           fits;

        if (k == 0) begin : g_first
            assign cur = st_in;
        end else begin : g_rest
            assign cur = st_q[k];
        end

        always_comb begin
            trial = {cur.rem, cur.num[NUM_W-1]};
            fits  = trial >= {1'b0, cur.den};
        end

        always_ff @(posedge clk) begin
            if (rst)      st_q[k+1].vld <= 1'b0;
            else if (adv) st_q[k+1].vld <= cur.vld;
            if (adv) begin
                st_q[k+1].rem <= fits ? DEN_W'(trial - {1'b0, cur.den}) : trial[DEN_W-1:0];
                st_q[k+1].quo <= {cur.quo[NUM_W-2:0], fits};
                st_q[k+1].num <= cur.num << 1;
                st_q[k+1].den <= cur.den;
                st_q[k+1].tag <= cur.tag;
            end
        end

        AST_REM_BELOW_DEN: assert property (@(posedge clk) disable iff (rst)
            (st_q[k+1].vld && st_q[k+1].den != '0) |-> (st_q[k+1].rem < st_q[k+1].den)); // R3
    end

    assign out_vld = st_q[NUM_W].vld;
    assign out_quo = st_q[NUM_W].quo;
    assign out_tag = st_q[NUM_W].tag;

endmodule

// File: rtl/rgbhsl_hue.sv
module rgbhsl_hue
    import rgbhsl_pkg::*;
#(
    parameter int QUO_W = DIV_NUM_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adv,
    input  logic             in_vld,
    input  logic [QUO_W-1:0] hue_quo,
    input  hue_tag_t         htag,
    input  logic [QUO_W-1:0] sat_quo,
    input  side_t            side,
    output logic             out_vld,
    output logic [DEG_W-1:0] hue_deg,
    output logic [CH_W-1:0]  sat,
    output logic [CH_W-1:0]  light
);

    localparam int ACC_W = QUO_W + 2;

    logic signed [ACC_W-1:0] base, mag, raw, rot;
    logic [CH_W-1:0]         sat_n;

    always_comb begin
        base = ACC_W'(sector_base(htag.sector));
        mag  = ACC_W'(hue_quo);
        raw  = htag.neg ? base - mag : base + mag;
        if (raw < 0)     raw = raw + ACC_W'(FULL_TURN);
        if (side.achrom) raw = '0;
        rot = raw + ACC_W'(side.offset);
        if (rot >= ACC_W'(FULL_TURN)) rot = rot - ACC_W'(FULL_TURN);
        if (side.achrom)                          sat_n = '0;
        else if (sat_quo > QUO_W'({CH_W{1'b1}}))  sat_n = {CH_W{1'b1}};
        else                                      sat_n = sat_quo[CH_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst)      out_vld <= 1'b0;
        else if (adv) out_vld <= in_vld;
        if (adv) begin
            hue_deg <= DEG_W'(rot);
            sat     <= sat_n;
            light   <= side.light;
        end
    end

    AST_SAT_FITS_BYTE: assert property (@(posedge clk) disable iff (rst)
        (in_vld && !side.achrom) |-> (sat_quo <= QUO_W'(255))); // R3
    AST_HUE_WRAPPED: assert property (@(posedge clk) disable iff (rst)
        out_vld |-> (hue_deg < DEG_W'(FULL_TURN))); // R6

endmodule

// File: rtl/rgbhsl_conv.sv
module rgbhsl_conv
    import rgbhsl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [PIX_W-1:0] in_pixel,
    input  logic [DEG_W-1:0] hue_offset,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [PIX_W-1:0] out_pixel
);

    localparam int SIDE_W = $bits(side_t);
    localparam int HTAG_W = $bits(hue_tag_t);

    logic                 adv;
    logic                 f_vld, s_vld, h_vld, fin_vld;
    logic [DIV_NUM_W-1:0] sat_num, hue_num, sat_quo, hue_quo;
    logic [DIV_DEN_W-1:0] sat_den, hue_den;
    side_t                f_side, d_side;
    hue_tag_t             f_htag, d_htag;
    logic [DEG_W-1:0]     fin_deg;
    logic [CH_W-1:0]      fin_sat, fin_light;
    logic                 unused_top_byte;

    // whole pipeline moves together unless a held result is blocked
    assign adv             = !out_valid || out_ready;
    assign in_ready        = adv;
    assign unused_top_byte = ^in_pixel[PIX_W-1:3*CH_W];

    rgbhsl_front front_i (
        .clk(clk), .rst(rst), .adv(adv), .in_vld(in_valid),
        .rgb(in_pixel[3*CH_W-1:0]), .offset(hue_offset),
        .vld_q(f_vld), .sat_num_q(sat_num), .sat_den_q(sat_den),
        .hue_num_q(hue_num), .hue_den_q(hue_den),
        .side_q(f_side), .htag_q(f_htag)
    );

    rgbhsl_div #(.NUM_W(DIV_NUM_W), .DEN_W(DIV_DEN_W), .TAG_W(SIDE_W)) sat_div_i (
        .clk(clk), .rst(rst), .adv(adv), .in_vld(f_vld),
        .in_num(sat_num), .in_den(sat_den), .in_tag(f_side),
        .out_vld(s_vld), .out_quo(sat_quo), .out_tag(d_side)
    );

    rgbhsl_div #(.NUM_W(DIV_NUM_W), .DEN_W(DIV_DEN_W), .TAG_W(HTAG_W)) hue_div_i (
        .clk(clk), .rst(rst), .adv(adv), .in_vld(f_vld),
        .in_num(hue_num), .in_den(hue_den), .in_tag(f_htag),
        .out_vld(h_vld), .out_quo(hue_quo), .out_tag(d_htag)
    );

    rgbhsl_hue #(.QUO_W(DIV_NUM_W)) hue_i (
        .clk(clk), .rst(rst), .adv(adv), .in_vld(s_vld),
        .hue_quo(hue_quo), .htag(d_htag), .sat_quo(sat_quo), .side(d_side),
        .out_vld(fin_vld), .hue_deg(fin_deg), .sat(fin_sat), .light(fin_light)
    );

    always_ff @(posedge clk) begin
        if (rst)      out_valid <= 1'b0;
        else if (adv) out_valid <= fin_vld;
        if (adv) out_pixel <= {{(PIX_W-3*CH_W){1'b0}}, deg_to_byte(fin_deg), fin_sat, fin_light};
    end

    AST_OUT_HELD: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_pixel))); // R9
    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !out_valid); // R10
    AST_DIV_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        s_vld == h_vld); // R8

endmodule

// File: tb/rgbhsl_conv_tb_top.sv
`timescale 1ns/100ps
module rgbhsl_conv_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic        in_ready;
    logic [31:0] in_pixel;
    logic [8:0]  hue_offset;
    logic        out_valid;
    logic        out_ready;
    logic [31:0] out_pixel;

    int n_chk = 0;
    int n_err = 0;
    int cyc   = 0;
    logic [31:0] exp_q [$];
    int          acc_q [$];
    bit lat_mode   = 1'b0;
    bit stall_mode = 1'b0;
    bit force_low  = 1'b0;
    bit hold_pend  = 1'b0;
    logic [31:0] held;

    localparam int EXP_LAT = 19; // 18 edges plus the sampling offset of one count

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    rgbhsl_conv dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_pixel(in_pixel), .hue_offset(hue_offset),
        .out_valid(out_valid), .out_ready(out_ready), .out_pixel(out_pixel)
    );

    task automatic check(bit ok, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_hsl(logic [31:0] p, int off);
        int r, g, b, mx, mn, d, sum, l, s, h, n, base, q;
        r = p[23:16]; g = p[15:8]; b = p[7:0];
        mx = (r > g) ? r : g; mx = (b > mx) ? b : mx;
        mn = (r < g) ? r : g; mn = (b < mn) ? b : mn;
        d = mx - mn; sum = mx + mn; l = sum / 2;
        if (d == 0) begin
            s = 0; h = 0;
        end else begin
            s = (l < 128) ? (d * 255) / sum : (d * 255) / (510 - sum);
            if (r == mx)      begin n = g - b; base = 0;   end
            else if (g == mx) begin n = b - r; base = 120; end
            else              begin n = r - g; base = 240; end
            q = (60 * ((n < 0) ? -n : n)) / d;
            h = (n < 0) ? base - q : base + q;
            if (h < 0) h = h + 360;
        end
        h = (h + off) % 360;
        h = (h * 256) / 360;
        return {8'h00, h[7:0], s[7:0], l[7:0]};
    endfunction

    // downstream readiness, changed at the falling edge
    initial forever begin
        @(negedge clk);
        if (force_low)       out_ready = 1'b0;
        else if (stall_mode) out_ready = ($urandom % 3) != 0;
        else                 out_ready = 1'b1;
    end

    // monitor / scoreboard
    initial forever begin
        @(negedge clk); #1;
        if (rst) begin
            hold_pend = 1'b0;
        end else begin
            logic [31:0] e;
            int a;
            if (hold_pend)
                check(out_valid && out_pixel == held, "R9 output held under stall", out_pixel, held);
            if (out_valid && !out_ready)
                check(!in_ready, "R9 input ready low under stall", 32'(in_ready), 32'h0);
            hold_pend = out_valid && !out_ready;
            held      = out_pixel;
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R9 extra output", out_pixel, 32'h0);
                end else begin
                    e = exp_q.pop_front();
                    a = acc_q.pop_front();
                    check(out_pixel[7:0] == e[7:0], "R2 lightness", out_pixel, e);
                    check(out_pixel[15:8] == e[15:8], "R3 saturation", out_pixel, e);
                    check(out_pixel[23:16] == e[23:16], "R4 hue", out_pixel, e);
                    check(out_pixel[31:24] == 8'h00, "R1 top byte zero", out_pixel, e);
                    if (lat_mode)
                        check(cyc - a == EXP_LAT, "R8 latency", 32'(cyc - a), 32'(EXP_LAT));
                end
            end
        end
    end

    task automatic send(logic [31:0] pix, int off);
        @(negedge clk);
        in_valid = 1'b1; in_pixel = pix; hue_offset = 9'(off);
        #1;
        while (!in_ready) begin @(negedge clk); #1; end
        exp_q.push_back(ref_hsl(pix, off));
        acc_q.push_back(cyc);
        @(posedge clk);
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic drain();
        for (int i = 0; i < 400; i++) begin
            if (exp_q.size() == 0) break;
            @(negedge clk);
        end
        check(exp_q.size() == 0, "R9 every pixel delivered", 32'(exp_q.size()), 32'h0);
    endtask

    initial begin
        #750000;
        n_chk++; n_err++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        rst = 1'b1; in_valid = 1'b0; in_pixel = '0; hue_offset = '0; out_ready = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0; #1;
        check(!out_valid, "R10 out_valid low after reset", 32'(out_valid), 32'h0);
        check(in_ready, "R10 in_ready high after reset", 32'(in_ready), 32'h1);

        // directed colour corners, back to back (R1, R4, R5, R6, R7, R8)
        lat_mode = 1'b1;
        send(32'hA5FF0000, 0);    // red, garbage top byte: R1, R4
        send(32'h0000FF00, 0);    // green
        send(32'h000000FF, 0);    // blue
        send(32'h00FFFF00, 0);    // yellow, red wins tie
        send(32'h0000FFFF, 0);    // cyan, green wins tie
        send(32'h00FF00FF, 0);    // magenta: negative hue wraps
        send(32'hFF000000, 0);    // black, achromatic: R5
        send(32'h00FFFFFF, 0);    // white, achromatic: R5
        send(32'h00808080, 200);  // grey with rotation: R5, R6
        send(32'h00FF0000, 360);  // rotation 360 equals 0: R6
        send(32'h00FF0000, 359);  // largest hue byte: R7
        send(32'h00FF0001, 0);    // slightly negative red sector
        send(32'h00C8C80A, 90);
        send(32'h007F8081, 0);    // lightness across 128 boundary
        send(32'h00010000, 180);
        idle();
        drain();

        // continuous random stream, no stalls
        for (int i = 0; i < 300; i++) send($urandom, $urandom_range(0, 360));
        idle();
        drain();

        // random stalls and input gaps (R9)
        lat_mode = 1'b0; stall_mode = 1'b1;
        for (int i = 0; i < 600; i++) begin
            send($urandom, $urandom_range(0, 360));
            if ($urandom % 4 == 0) idle();
        end
        idle();
        drain();
        stall_mode = 1'b0;

        // reset with a full, blocked pipeline (R10)
        force_low = 1'b1;
        for (int i = 0; i < 5; i++) send($urandom, 0);
        idle();
        repeat (25) @(negedge clk);
        #1;
        check(out_valid, "R9 result waits while blocked", 32'(out_valid), 32'h1);
        check(!in_ready, "R9 input blocked while output blocked", 32'(in_ready), 32'h0);
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk);
        exp_q.delete(); acc_q.delete();
        rst = 1'b0; force_low = 1'b0;
        for (int i = 0; i < 25; i++) begin
            @(negedge clk); #1;
            check(!out_valid, "R10 no output after reset", 32'(out_valid), 32'h0);
        end
        check(in_ready, "R10 in_ready after mid-run reset", 32'(in_ready), 32'h1);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule